// File: doc/BRIEF.md
# Bit-Pair Lane Gearbox

This block sits between a 16-bit parallel burst bus and eight independent 8-bit symbol lanes that feed block codecs (a 32-symbol codeword per lane, 24 of them data). The bus carries successive words taken from a fast serial stream, so each bus bit runs at one sixteenth of the line rate. Every lane owns a fixed pair of adjacent bus bits. Four bus words therefore build one symbol per lane, and the symbol rate is a quarter of the bus word rate.

On the receive side the gearbox gathers bit pairs into symbols and presents all eight lane symbols together with a one-cycle valid pulse. A packet-start strobe realigns the symbol boundary to the first word of every burst. A packet-end strobe flushes a partly filled symbol, pads it with zeros and flags it as the last one. On the transmit side it takes eight lane symbols at a time and spreads them back onto the bus, one bit pair per lane per word, with start and end markers for the serialiser that follows. Both directions share one clock.

Top module: `pair_lane_gearbox`

## Requirements
- R1: Lane k uses bus bits 2k+1:2k and appears on symbol bits 8k+7:8k. The pair from the earliest word of a symbol lands in symbol bits [7:6], the next in [5:4], then [3:2], then [1:0]. The transmit side uses the same mapping in reverse.
- R2: rx_sym_valid pulses for one cycle, in the cycle after the clock edge that accepts the fourth word of a symbol. With words on every cycle it pulses once every four cycles, and it stays low after the first three words.
- R3: A word with rx_valid and rx_start becomes position 0 of a new symbol. Any partly gathered symbol is dropped without an output pulse.
- R4: While rx_valid is low the word, rx_start and rx_end are ignored. Assembly pauses, and rx_sym, rx_sym_valid and rx_sym_last show no new symbol.
- R5: A word with rx_valid and rx_end completes the current symbol in the next cycle with rx_sym_last high and the unfilled low bits zero. rx_sym_fill gives the number of words held minus one (3 for a full symbol, 0 for one word).
- R6: After synchronous reset every output is zero and tx_word_valid is low.
- R7: On the cycle after tx_sym_valid is accepted, tx_word_valid goes high and carries the symbols' first pairs. The following three cycles carry the remaining pairs in order.
- R8: A new symbol accepted on the cycle its predecessor shows its fourth word continues the bus stream with no idle cycle.
- R9: tx_word_start is high on the first word shown after reset or after a word marked tx_word_end, and low on all other words.
- R10: A symbol offered with tx_sym_last and tx_sym_fill = f produces only f+1 words. The final word carries tx_word_end.
- R11: tx_sym_valid offered while a symbol still has words left after the current one is ignored. The word stream of the current symbol continues unchanged.
- R12: tx_word is all zeros whenever tx_word_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both directions |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 16 | Incoming parallel bus word |
| rx_valid | input | 1 | rx_word holds a word this cycle |
| rx_start | input | 1 | This word opens a packet |
| rx_end | input | 1 | This word closes a packet |
| rx_sym | output | 64 | Eight lane symbols, lane k in bits 8k+7:8k |
| rx_sym_valid | output | 1 | rx_sym holds a new symbol set |
| rx_sym_last | output | 1 | This symbol set closes the packet |
| rx_sym_fill | output | 2 | Words held in this symbol minus one |
| tx_sym | input | 64 | Eight lane symbols to transmit |
| tx_sym_valid | input | 1 | Offer tx_sym for transmission |
| tx_sym_last | input | 1 | Offered symbol closes the packet |
| tx_sym_fill | input | 2 | Words to send from a final symbol minus one |
| tx_word | output | 16 | Outgoing parallel bus word |
| tx_word_valid | output | 1 | tx_word holds a word this cycle |
| tx_word_start | output | 1 | First word of a packet |
| tx_word_end | output | 1 | Last word of a packet |

## Verification
The checker assumes that a symbol offer on the transmit side arrives only when the serialiser is idle or showing its final word, so that every offer leads to words on the next cycle. The bench honours this in all cases except the one scenario that checks R11 on purpose, and there the offer falls in the middle of a symbol where the word stream would continue anyway. The receive properties take rx_start and rx_end as meaningful only alongside rx_valid. The gap scenario drives both strobes while rx_valid is low to show that they have no effect.

// File: rtl/plg_pkg.sv
package plg_pkg;
    localparam int DEF_BUS_W  = 16;
    localparam int DEF_PAIR_W = 2;
    localparam int DEF_SYM_W  = 8;

    // per-word receive control shared by every lane
    typedef struct packed {
        logic take;   // word accepted
        logic clear;  // word is position 0: drop old accumulator
        logic emit;   // symbol completes on this word
        logic last;   // packet closes on this word
    } rx_ctl_t;

    // left shift that places a pair at position pos (0 = most significant)
    function automatic int pair_shift(input int sym_w, input int pair_w, input int pos);
        return sym_w - pair_w * (pos + 1);
    endfunction
endpackage

// File: rtl/plg_rx_seq.sv
module plg_rx_seq
    import plg_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int POS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic             start_i,
    input  logic             end_i,
    output logic [POS_W-1:0] pos_o,
    output rx_ctl_t          ctl_o
);
    logic [POS_W-1:0] cnt_q;

    always_comb begin
        pos_o       = start_i ? '0 : cnt_q;
        ctl_o.take  = valid_i;
        ctl_o.clear = (pos_o == '0);
        ctl_o.last  = valid_i & end_i;
        ctl_o.emit  = valid_i & (end_i | (pos_o == POS_W'(WORDS - 1)));
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (valid_i)
            cnt_q <= ctl_o.emit ? '0 : pos_o + 1'b1;
    end
endmodule

// File: rtl/plg_lane_pack.sv
module plg_lane_pack
    import plg_pkg::*;
#(
    parameter int PAIR_W = 2,
    parameter int SYM_W  = 8,
    parameter int POS_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAIR_W-1:0] pair_i,
    input  logic [POS_W-1:0]  pos_i,
    input  rx_ctl_t           ctl_i,
    output logic [SYM_W-1:0]  sym_o
);
    logic [SYM_W-1:0] acc_q, base, merged;

    always_comb begin
        base   = ctl_i.clear ? '0 : acc_q;
        merged = base | (SYM_W'(pair_i) << pair_shift(SYM_W, PAIR_W, int'(pos_i)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            sym_o <= '0;
        end else if (ctl_i.take) begin
            acc_q <= ctl_i.emit ? '0 : merged;
            if (ctl_i.emit)
                sym_o <= merged;
        end
    end
endmodule

// File: rtl/plg_tx_seq.sv
module plg_tx_seq #(
    parameter int WORDS = 4,
    parameter int POS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             offer_i,
    input  logic             last_i,
    input  logic [POS_W-1:0] fill_i,
    output logic             load_o,
    output logic             shift_o,
    output logic             busy_o,
    output logic             start_o,
    output logic             end_o
);
    logic             busy_q, last_q, first_q;
    logic [POS_W-1:0] left_q;
    logic             final_word;

    always_comb begin
        final_word = busy_q & (left_q == '0);
        load_o     = offer_i & (~busy_q | final_word);
        shift_o    = busy_q & ~load_o;
        busy_o     = busy_q;
        start_o    = busy_q & first_q;
        end_o      = final_word & last_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            last_q  <= 1'b0;
            first_q <= 1'b1;
            left_q  <= '0;
        end else begin
            if (busy_q)
                first_q <= end_o;
            if (load_o) begin
                busy_q <= 1'b1;
                last_q <= last_i;
                left_q <= last_i ? fill_i : POS_W'(WORDS - 1);
            end else if (busy_q) begin
                if (left_q == '0)
                    busy_q <= 1'b0;
                else
                    left_q <= left_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/plg_lane_unpack.sv
module plg_lane_unpack #(
    parameter int PAIR_W = 2,
    parameter int SYM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              en_i,
    input  logic [SYM_W-1:0]  sym_i,
    output logic [PAIR_W-1:0] pair_o
);
    logic [SYM_W-1:0] sh_q;

    assign pair_o = sh_q[SYM_W-1 -: PAIR_W] & {PAIR_W{en_i}};

    always_ff @(posedge clk) begin
        if (rst)
            sh_q <= '0;
        else if (load_i)
            sh_q <= sym_i;
        else if (shift_i)
            sh_q <= sh_q << PAIR_W;
    end
endmodule

// File: rtl/pair_lane_gearbox.sv
module pair_lane_gearbox
    import plg_pkg::*;
#(
    parameter int  BUS_W  = DEF_BUS_W,
    parameter int  PAIR_W = DEF_PAIR_W,
    parameter int  SYM_W  = DEF_SYM_W,
    localparam int LANES  = BUS_W / PAIR_W,
    localparam int WORDS  = SYM_W / PAIR_W,
    localparam int POS_W  = $clog2(WORDS),
    localparam int SYMS_W = LANES * SYM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  rx_word,
    input  logic              rx_valid,
    input  logic              rx_start,
    input  logic              rx_end,
    output logic [SYMS_W-1:0] rx_sym,
    output logic              rx_sym_valid,
    output logic              rx_sym_last,
    output logic [POS_W-1:0]  rx_sym_fill,
    input  logic [SYMS_W-1:0] tx_sym,
    input  logic              tx_sym_valid,
    input  logic              tx_sym_last,
    input  logic [POS_W-1:0]  tx_sym_fill,
    output logic [BUS_W-1:0]  tx_word,
    output logic              tx_word_valid,
    output logic              tx_word_start,
    output logic              tx_word_end
);
    logic [POS_W-1:0] rx_pos;
    rx_ctl_t          rx_ctl;
    logic             tx_load, tx_shift, tx_busy;

    plg_rx_seq #(.WORDS(WORDS), .POS_W(POS_W)) u_rx_seq (
        .clk(clk), .rst(rst), .valid_i(rx_valid), .start_i(rx_start),
        .end_i(rx_end), .pos_o(rx_pos), .ctl_o(rx_ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sym_valid <= 1'b0;
            rx_sym_last  <= 1'b0;
            rx_sym_fill  <= '0;
        end else begin
            rx_sym_valid <= rx_ctl.emit;
            rx_sym_last  <= rx_ctl.last;
            if (rx_ctl.emit)
                rx_sym_fill <= rx_pos;
        end
    end

    plg_tx_seq #(.WORDS(WORDS), .POS_W(POS_W)) u_tx_seq (
        .clk(clk), .rst(rst), .offer_i(tx_sym_valid), .last_i(tx_sym_last),
        .fill_i(tx_sym_fill), .load_o(tx_load), .shift_o(tx_shift),
        .busy_o(tx_busy), .start_o(tx_word_start), .end_o(tx_word_end)
    );

    assign tx_word_valid = tx_busy;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        plg_lane_pack #(.PAIR_W(PAIR_W), .SYM_W(SYM_W), .POS_W(POS_W)) u_pack (
            .clk(clk), .rst(rst),
            .pair_i(rx_word[k*PAIR_W +: PAIR_W]),
            .pos_i(rx_pos), .ctl_i(rx_ctl),
            .sym_o(rx_sym[k*SYM_W +: SYM_W])
        );
        plg_lane_unpack #(.PAIR_W(PAIR_W), .SYM_W(SYM_W)) u_unpack (
            .clk(clk), .rst(rst),
            .load_i(tx_load), .shift_i(tx_shift), .en_i(tx_busy),
            .sym_i(tx_sym[k*SYM_W +: SYM_W]),
            .pair_o(tx_word[k*PAIR_W +: PAIR_W])
        );
    end
endmodule

// File: rtl/plg_checker.sv
module plg_checker #(
    parameter int BUS_W  = 16,
    parameter int SYMS_W = 64,
    parameter int POS_W  = 2,
    parameter int WORDS  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic              rx_end,
    input logic [SYMS_W-1:0] rx_sym,
    input logic              rx_sym_valid,
    input logic              rx_sym_last,
    input logic [POS_W-1:0]  rx_sym_fill,
    input logic              tx_sym_valid,
    input logic [BUS_W-1:0]  tx_word,
    input logic              tx_word_valid,
    input logic              tx_word_start,
    input logic              tx_word_end
);
    assert_no_word_no_sym_R2: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !rx_sym_valid);

    assert_gap_holds_sym_R4: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(rx_sym));

    assert_end_flushes_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_end) |=> (rx_sym_valid && rx_sym_last));

    assert_full_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_sym_valid && !rx_sym_last) |-> (rx_sym_fill == POS_W'(WORDS - 1)));

    assert_offer_yields_word_R7: assert property (@(posedge clk) disable iff (rst)
        tx_sym_valid |=> tx_word_valid);

    assert_start_qualified_R9: assert property (@(posedge clk) disable iff (rst)
        tx_word_start |-> tx_word_valid);

    assert_end_qualified_R10: assert property (@(posedge clk) disable iff (rst)
        tx_word_end |-> tx_word_valid);

    assert_idle_bus_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !tx_word_valid |-> (tx_word == '0));
endmodule

bind pair_lane_gearbox plg_checker #(
    .BUS_W(BUS_W), .SYMS_W(SYMS_W), .POS_W(POS_W), .WORDS(WORDS)
) u_plg_checker (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_end(rx_end),
    .rx_sym(rx_sym), .rx_sym_valid(rx_sym_valid), .rx_sym_last(rx_sym_last),
    .rx_sym_fill(rx_sym_fill), .tx_sym_valid(tx_sym_valid), .tx_word(tx_word),
    .tx_word_valid(tx_word_valid), .tx_word_start(tx_word_start),
    .tx_word_end(tx_word_end)
);

// File: tb/pair_lane_gearbox_test.sv
module pair_lane_gearbox_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] rx_word;
    logic        rx_valid, rx_start, rx_end;
    logic [63:0] rx_sym;
    logic        rx_sym_valid, rx_sym_last;
    logic [1:0]  rx_sym_fill;
    logic [63:0] tx_sym;
    logic        tx_sym_valid, tx_sym_last;
    logic [1:0]  tx_sym_fill;
    logic [15:0] tx_word;
    logic        tx_word_valid, tx_word_start, tx_word_end;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    pair_lane_gearbox uut (
        .clk(clk), .rst(rst),
        .rx_word(rx_word), .rx_valid(rx_valid), .rx_start(rx_start), .rx_end(rx_end),
        .rx_sym(rx_sym), .rx_sym_valid(rx_sym_valid), .rx_sym_last(rx_sym_last),
        .rx_sym_fill(rx_sym_fill),
        .tx_sym(tx_sym), .tx_sym_valid(tx_sym_valid), .tx_sym_last(tx_sym_last),
        .tx_sym_fill(tx_sym_fill),
        .tx_word(tx_word), .tx_word_valid(tx_word_valid),
        .tx_word_start(tx_word_start), .tx_word_end(tx_word_end)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus word p (0 = earliest) carrying the symbols of all lanes, per R1
    function automatic logic [15:0] word_of(input logic [63:0] syms, input int p);
        logic [15:0] w;
        for (int k = 0; k < 8; k++)
            w[2*k +: 2] = syms[8*k + 6 - 2*p +: 2];
        return w;
    endfunction

    function automatic logic [63:0] rand_syms();
        return {$urandom, $urandom};
    endfunction

    task automatic rx_drive(input logic [15:0] w, input logic v, input logic s, input logic e);
        rx_word = w; rx_valid = v; rx_start = s; rx_end = e;
        step();
        rx_valid = 0; rx_start = 0; rx_end = 0;
    endtask

    task automatic t_reset();
        check("R6 rx_sym", rx_sym, 0);
        check("R6 rx flags", {rx_sym_valid, rx_sym_last, rx_sym_fill}, 0);
        check("R6 tx_word", tx_word, 0);
        check("R6 tx flags", {tx_word_valid, tx_word_start, tx_word_end}, 0);
    endtask

    task automatic t_rx_full();
        logic [63:0] s = rand_syms();
        for (int p = 0; p < 4; p++) begin
            rx_drive(word_of(s, p), 1, p == 0, 0);
            if (p < 3) check("R2 no early valid", rx_sym_valid, 0);
        end
        check("R2 valid after fourth", rx_sym_valid, 1);
        check("R1 lane mapping", rx_sym, s);
        check("R5 full fill", {rx_sym_last, rx_sym_fill}, {1'b0, 2'd3});
        step();
        check("R2 single pulse", rx_sym_valid, 0);
    endtask

    task automatic t_rx_stream();
        logic [63:0] s [3];
        for (int i = 0; i < 3; i++) s[i] = rand_syms();
        for (int i = 0; i < 3; i++)
            for (int p = 0; p < 4; p++) begin
                rx_drive(word_of(s[i], p), 1, i == 0 && p == 0, i == 2 && p == 3);
                if (p == 3) begin
                    check("R2 stream symbol", rx_sym, s[i]);
                    check("R2 stream valid", rx_sym_valid, 1);
                    check("R5 last flag", rx_sym_last, i == 2);
                end else
                    check("R2 stream idle", rx_sym_valid, 0);
            end
    endtask

    task automatic t_rx_gaps();
        logic [63:0] s = rand_syms();
        for (int p = 0; p < 4; p++) begin
            rx_drive(word_of(s, p), 1, p == 0, 0);
            if (p < 3) begin
                rx_drive(16'hFFFF, 0, 1, 1);   // junk, start and end without valid
                check("R4 gap no symbol", {rx_sym_valid, rx_sym_last}, 0);
            end
        end
        check("R4 gapped symbol", rx_sym, s);
        check("R4 gapped flags", {rx_sym_valid, rx_sym_last, rx_sym_fill}, {1'b1, 1'b0, 2'd3});
    endtask

    task automatic t_rx_partial();
        logic [63:0] s = rand_syms();
        rx_drive(word_of(s, 0), 1, 1, 0);
        rx_drive(word_of(s, 1), 1, 0, 1);
        check("R5 two-word pad", rx_sym, s & {8{8'hF0}});
        check("R5 two-word flags", {rx_sym_valid, rx_sym_last, rx_sym_fill}, {1'b1, 1'b1, 2'd1});
        s = rand_syms();
        rx_drive(word_of(s, 0), 1, 1, 1);
        check("R5 one-word pad", rx_sym, s & {8{8'hC0}});
        check("R5 one-word flags", {rx_sym_valid, rx_sym_last, rx_sym_fill}, {1'b1, 1'b1, 2'd0});
    endtask

    task automatic t_rx_restart();
        logic [63:0] a = rand_syms();
        logic [63:0] b = rand_syms();
        rx_drive(word_of(a, 0), 1, 1, 0);
        rx_drive(word_of(a, 1), 1, 0, 0);
        for (int p = 0; p < 4; p++) begin
            rx_drive(word_of(b, p), 1, p == 0, 0);
            if (p < 3) check("R3 partial dropped", rx_sym_valid, 0);
        end
        check("R3 realigned symbol", rx_sym, b);
        check("R3 realigned valid", rx_sym_valid, 1);
    endtask

    task automatic tx_offer(input logic [63:0] s, input logic last, input logic [1:0] fill);
        tx_sym = s; tx_sym_valid = 1; tx_sym_last = last; tx_sym_fill = fill;
    endtask

    task automatic t_tx_single();
        logic [63:0] s = rand_syms();
        tx_offer(s, 1, 2'd3);
        step();
        tx_sym_valid = 0;
        for (int p = 0; p < 4; p++) begin
            check("R7 word", tx_word, word_of(s, p));
            check("R7 valid", tx_word_valid, 1);
            check("R9 start", tx_word_start, p == 0);
            check("R10 end", tx_word_end, p == 3);
            step();
        end
        check("R12 idle zero", {tx_word_valid, tx_word}, 0);
    endtask

    task automatic t_tx_b2b();
        logic [63:0] s [3];
        for (int i = 0; i < 3; i++) s[i] = rand_syms();
        tx_offer(s[0], 0, 2'd0);
        step();
        tx_sym_valid = 0;
        for (int i = 0; i < 3; i++)
            for (int p = 0; p < (i == 2 ? 2 : 4); p++) begin
                check("R8 word", tx_word, word_of(s[i], p));
                check("R8 no bubble", tx_word_valid, 1);
                check("R9 start once", tx_word_start, i == 0 && p == 0);
                check("R10 end", tx_word_end, i == 2 && p == 1);
                if (p == 3) tx_offer(s[i+1], i + 1 == 2, 2'd1);
                step();
                tx_sym_valid = 0;
            end
        check("R10 short symbol stops", tx_word_valid, 0);
        check("R12 zero after end", tx_word, 0);
    endtask

    task automatic t_tx_ignore();
        logic [63:0] a = rand_syms();
        logic [63:0] b = rand_syms();
        logic [63:0] c = rand_syms();
        tx_offer(a, 0, 2'd0);
        step();
        tx_sym_valid = 0;
        for (int p = 0; p < 4; p++) begin
            check("R11 word kept", tx_word, word_of(a, p));
            check("R11 no end", tx_word_end, 0);
            if (p == 0) tx_offer(b, 1, 2'd3);
            if (p == 3) tx_offer(c, 1, 2'd3);
            step();
            tx_sym_valid = 0;
        end
        for (int p = 0; p < 4; p++) begin
            check("R11 following word", tx_word, word_of(c, p));
            check("R9 no restart", tx_word_start, 0);
            check("R10 end", tx_word_end, p == 3);
            step();
        end
        check("R12 zero when idle", {tx_word_valid, tx_word}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; rx_word = 0; rx_valid = 0; rx_start = 0; rx_end = 0;
        tx_sym = 0; tx_sym_valid = 0; tx_sym_last = 0; tx_sym_fill = 0;
        repeat (3) step();
        t_reset();
        rst = 0;
        step();
        t_rx_full();
        t_rx_stream();
        t_rx_gaps();
        t_rx_partial();
        t_rx_restart();
        t_tx_single();
        t_tx_b2b();
        t_tx_ignore();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule